// File: doc/BRIEF.md
# Packed Horizontal Pairwise Adder

This unit is a SIMD datapath stage that adds each pair of neighbouring signed elements within a source vector. It writes the pair sums from two sources into a single 256-bit destination. An opcode byte selects 16-bit or 32-bit elements. A two-bit mode selects one of three destination behaviours:

- **Legacy 128-bit:** the destination doubles as the first source, and its upper half is preserved.
- **Short vector 128-bit:** the upper half of the destination is cleared.
- **Long vector 256-bit:** two independent 128-bit lanes are processed.

A single `start` strobe captures the operands. The result appears one clock later, together with a one-cycle `res_vld` pulse. The result stays unchanged until the next strobe.

Top module: `hpair_add_unit`

## Requirements
- R1: With `opc` = 0x01 (16-bit elements), result word j of a 128-bit lane, for j in 0..3, equals first-source word 2j plus word 2j+1. Result word 4+j equals second-source word 2j plus word 2j+1. Words are numbered from bit 0 upward within the lane.
- R2: Any `opc` value other than 0x01, including 0x02, selects 32-bit elements. Result dword j of a lane, for j in 0..1, is first-source dword 2j plus dword 2j+1. Result dword 2+j is the second-source pair sum.
- R3: Sums wrap modulo 2^16 or 2^32: 0x7FFF+0x7FFF gives 0xFFFE, and 0x8000+0x8000 gives 0x0000, with no saturation.
- R4: In mode 2 (long vector), bits 127:0 depend only on bits 127:0 of both sources. Bits 255:128 are computed in the same way only from bits 255:128 of both sources.
- R5: In mode 0 (legacy), the first source is `dst_old`, and `src_a` has no effect on the result. Bits 255:128 of the result equal `dst_old[255:128]`.
- R6: In mode 1 (short vector), and in the reserved mode 3, result bits 255:128 are zero and the first source is `src_a`.
- R7: Operands are sampled on a clock edge where `start` is high. `res` shows the result and `res_vld` is high for exactly the following cycle. `res` holds its value while `start` is low.
- R8: Synchronous active-high `rst` clears `res` and `res_vld` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for operands |
| opc | input | 8 | Element size select (0x01 words, else dwords) |
| mode | input | 2 | 0 legacy, 1 short vector, 2 long vector, 3 reserved |
| src_a | input | 256 | First source (vector modes) |
| src_b | input | 256 | Second source |
| dst_old | input | 256 | Previous destination value |
| res | output | 256 | Packed pair sums |
| res_vld | output | 1 | One-cycle result strobe |

## Verification
Each scenario below names a corner case and what a faulty design would show:

- **Saturating operands** (all elements at the positive or negative extreme) show whether a design saturates or widens instead of wrapping. A faulty design shows 0x7FFF or carry bits leaking into the next element.
- **Legacy mode with two different `src_a` patterns** would expose a design that reads the wrong first operand, because the result would change.
- **Long-vector mode with distinct upper-lane data** catches pairs that cross the lane boundary and an upper half copied from the lower lane.
- **Ordering within a lane:** distinct element values catch a design that swaps the halves or interleaves the two sources.
- **Quiet cycles after a strobe** show whether the output drifts with the live inputs.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  typedef enum logic [1:0] {
    MD_LEG  = 2'd0,
    MD_V128 = 2'd1,
    MD_V256 = 2'd2,
    MD_RSV  = 2'd3
  } hpa_mode_e;

  localparam logic [7:0] OPC_WORD = 8'h01;
endpackage

// File: rtl/hpa_pack.sv
// Pairwise sums for one element width inside one lane.
module hpa_pack #(
  parameter int LANE_W = 128,
  parameter int EW     = 16
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);
  localparam int NE   = LANE_W / EW;
  localparam int NP   = NE / 2;
  localparam int HALF = LANE_W / 2;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign y[p*EW +: EW]        = a[(2*p)*EW +: EW] + a[(2*p+1)*EW +: EW];
    assign y[HALF + p*EW +: EW] = b[(2*p)*EW +: EW] + b[(2*p+1)*EW +: EW];
  end
endmodule

// File: rtl/hpa_lane.sv
// One 128-bit lane: both element widths, selected by use_word.
module hpa_lane #(
  parameter int LANE_W = 128
) (
  input  logic              use_word,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);
  logic [LANE_W-1:0] y_w, y_d;

  hpa_pack #(.LANE_W(LANE_W), .EW(16)) u_w (.a(a), .b(b), .y(y_w));
  hpa_pack #(.LANE_W(LANE_W), .EW(32)) u_d (.a(a), .b(b), .y(y_d));

  assign y = use_word ? y_w : y_d;
endmodule

// File: rtl/hpair_add_unit.sv
module hpair_add_unit #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       opc,
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] dst_old,
  output logic [VEC_W-1:0] res,
  output logic             res_vld
);
  import hpa_pkg::*;

  localparam int NLANE = VEC_W / LANE_W;

  hpa_mode_e        md;
  logic             use_word;
  logic [VEC_W-1:0] first;
  logic [VEC_W-1:0] nxt;

  assign md       = hpa_mode_e'(mode);
  assign use_word = (opc == OPC_WORD);
  assign first    = (md == MD_LEG) ? dst_old : src_a;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [LANE_W-1:0] ly;

    hpa_lane #(.LANE_W(LANE_W)) u_lane (
      .use_word (use_word),
      .a        (first[k*LANE_W +: LANE_W]),
      .b        (src_b[k*LANE_W +: LANE_W]),
      .y        (ly)
    );

    if (k == 0) begin : g_low
      assign nxt[LANE_W-1:0] = ly;
    end else begin : g_up
      assign nxt[k*LANE_W +: LANE_W] =
        (md == MD_V256) ? ly :
        (md == MD_LEG)  ? dst_old[k*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= start;
      if (start) res <= nxt;
    end
  end
endmodule

// File: rtl/hpa_chk.sv
module hpa_chk #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [7:0]       opc,
  input logic [1:0]       mode,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] dst_old,
  input logic [VEC_W-1:0] res,
  input logic             res_vld
);
  // R7
  vld_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> res_vld);
  // R7
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_vld);
  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(res));
  // R6
  short_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (mode == 2'd1 || mode == 2'd3)) |=> (res[VEC_W-1:LANE_W] == '0));
  // R5
  legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 2'd0) |=> (res[VEC_W-1:LANE_W] == $past(dst_old[VEC_W-1:LANE_W])));
  // R1
  low_word_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 2'd2 && opc == 8'h01) |=>
      (res[15:0] == 16'($past(src_a[15:0]) + $past(src_a[31:16]))));
endmodule

bind hpair_add_unit hpa_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_hpair_add_unit.sv
module tb_hpair_add_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [7:0]   opc = 8'h01;
  logic [1:0]   mode = 2'd0;
  logic [255:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [255:0] res;
  logic         res_vld;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  hpair_add_unit dut (.*);

  function automatic logic [255:0] model(input logic [7:0] op, input logic [1:0] md,
                                         input logic [255:0] a, b, d);
    logic [255:0] r, f;
    int nl;
    r  = '0;
    f  = (md == 2'd0) ? d : a;
    nl = (md == 2'd2) ? 2 : 1;
    for (int l = 0; l < nl; l++) begin
      if (op == 8'h01) begin
        for (int j = 0; j < 4; j++) begin
          r[l*128 + j*16 +: 16]      = 16'(f[l*128 + 32*j +: 16] + f[l*128 + 32*j + 16 +: 16]);
          r[l*128 + 64 + j*16 +: 16] = 16'(b[l*128 + 32*j +: 16] + b[l*128 + 32*j + 16 +: 16]);
        end
      end else begin
        for (int j = 0; j < 2; j++) begin
          r[l*128 + j*32 +: 32]      = 32'(f[l*128 + 64*j +: 32] + f[l*128 + 64*j + 32 +: 32]);
          r[l*128 + 64 + j*32 +: 32] = 32'(b[l*128 + 64*j +: 32] + b[l*128 + 64*j + 32 +: 32]);
        end
      end
    end
    if (md == 2'd0) r[255:128] = d[255:128];
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [7:0] op, input logic [1:0] md,
                     input logic [255:0] a, b, d);
    @(negedge clk);
    opc = op; mode = md; src_a = a; src_b = b; dst_old = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 vld"}, {255'd0, res_vld}, 256'd1);
    check(tag, res, model(op, md, a, b, d));
  endtask

  function automatic logic [255:0] ramp16(input int base);
    logic [255:0] v;
    for (int i = 0; i < 16; i++) v[i*16 +: 16] = 16'(base + 3*i);
    return v;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R8 res", res, '0);
    check("R8 vld", {255'd0, res_vld}, '0);
  endtask

  task automatic t_words();
    run("R1 words v256", 8'h01, 2'd2, ramp16(1), ramp16(100), '0);
    run("R1 words v128", 8'h01, 2'd1, ramp16(7), ramp16(-50), {256{1'b1}});
  endtask

  task automatic t_dwords();
    run("R2 dwords op02", 8'h02, 2'd2, ramp16(9), ramp16(300), '0);
    run("R2 dwords op7f", 8'h7f, 2'd1, ramp16(21), ramp16(4000), '0);
  endtask

  task automatic t_overflow();
    run("R3 wmax", 8'h01, 2'd2, {16{16'h7fff}}, {16{16'h8000}}, '0);
    check("R3 wmax lit", res, {{4{16'h0000}}, {4{16'hfffe}}, {4{16'h0000}}, {4{16'hfffe}}});
    run("R3 dmax", 8'h02, 2'd2, {8{32'h7fffffff}}, {8{32'hffffffff}}, '0);
    check("R3 dmax lit", res, {{2{32'hfffffffe}}, {2{32'hfffffffe}}, {2{32'hfffffffe}}, {2{32'hfffffffe}}});
  endtask

  task automatic t_lanes();
    logic [255:0] a2, b2, keep;
    a2 = {ramp16(500)[127:0], ramp16(2)[127:0]};
    b2 = {ramp16(-9)[127:0], ramp16(77)[127:0]};
    run("R4 lanes", 8'h01, 2'd2, a2, b2, '0);
    keep = res;
    run("R4 upper change", 8'h01, 2'd2, {~a2[255:128], a2[127:0]}, b2, '0);
    check("R4 low lane unaffected", {128'd0, res[127:0]}, {128'd0, keep[127:0]});
  endtask

  task automatic t_legacy();
    logic [255:0] d, first;
    d = ramp16(1234);
    run("R5 legacy", 8'h01, 2'd0, ramp16(5), ramp16(60), d);
    first = res;
    run("R5 legacy srca", 8'h01, 2'd0, ~ramp16(5), ramp16(60), d);
    check("R5 srca ignored", res, first);
    run("R5 legacy dw", 8'h02, 2'd0, '0, ramp16(11), d);
  endtask

  task automatic t_short();
    run("R6 mode3", 8'h01, 2'd3, ramp16(40), ramp16(41), {256{1'b1}});
  endtask

  task automatic t_hold();
    logic [255:0] held;
    run("R7 base", 8'h01, 2'd2, ramp16(3), ramp16(4), '0);
    held = res;
    src_a = ~src_a; src_b = ~src_b; mode = 2'd0;
    @(negedge clk);
    check("R7 vld drop", {255'd0, res_vld}, '0);
    @(negedge clk);
    check("R7 hold", res, held);
  endtask

  task automatic t_reset_clear();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 clear", res, '0);
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_words();
    t_dwords();
    t_overflow();
    t_lanes();
    t_legacy();
    t_short();
    t_hold();
    t_reset_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule